// File: doc/BRIEF.md
# Sector signature pattern checker

This block judges whether a marginal sector signature is present on a disk. It does not read the disk itself. It asks for reads and seeks through a one-cycle request. An outside controller answers each request with a byte stream, and the block checks that stream as it arrives.

Each attempt on a track is a pair of reads of the same sector position. The first read is in data mode and the second in clock mode. In each read, a leading region is skipped. After it comes a short run of bytes that must equal a constant, and the constant depends on the mode. Last comes a window whose cleared-bit count must reach a threshold. Because of this threshold, a few flipped bits from read drift do not fail an attempt.

Failed attempts are retried on the same track up to a limit. After that the block seeks to the next track in ascending order. It stops at the first track where both reads pass, or after the last track fails. The verdict is held until the next start.

Top module: `sigchk_top`

## Requirements
- R1: After reset, req_vld, busy, done and pass are all 0.
- R2: In the cycle after start is sampled high, req_vld is 1 with req_seek=1, req_trk=7 and req_mode=0. Mode encoding: 0 is data mode, 1 is clock mode.
- R3: The first 64 accepted bytes of a read are ignored, whatever their values.
- R4: Accepted bytes 64 to 79 (counting from 0) must equal 0xFF in mode 0, or 0x00 in mode 1. A mismatching byte ends the attempt as failed, and the next request or done appears in the cycle after that byte is accepted.
- R5: Accepted bytes 80 to 111 pass only if they contain at least 204 cleared bits in total. A count of 204 passes and 203 fails. The verdict appears in the cycle after byte 111 is accepted.
- R6: A passing mode-0 read is followed by a mode-1 request on the same track with req_seek=0.
- R7: A failed attempt in either mode is followed by a mode-0 request on the same track with req_seek=0, until 5 attempts on that track have failed.
- R8: After the 5th failed attempt on a track below 10, the next request has req_seek=1 and req_trk one higher, in mode 0. Tracks are visited in the order 7, 8, 9, 10.
- R9: A passing mode-1 read sets done=1 and pass=1, with req_trk holding the passing track. A 5th failure on track 10 sets done=1 and pass=0. Both outputs hold until the next start.
- R10: Bytes are accepted only when byte_vld is 1 and a read is outstanding (busy=1, req_vld=0). Bytes offered while idle, while done, or in a request cycle have no effect.
- R11: A start during a search abandons it: all counters clear and the R2 request follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) the search |
| byte_vld | input | 1 | byte_data carries a read byte this cycle |
| byte_data | input | 8 | Byte from the sector read |
| req_vld | output | 1 | One-cycle request for a new read |
| req_seek | output | 1 | The request needs a seek to req_trk first |
| req_trk | output | 4 | Track of the request, and the final track when done |
| req_mode | output | 1 | 0 data mode, 1 clock mode |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished |
| pass | output | 1 | Verdict, valid while done |

## Verification
The hardest state to reach is the exhausted search: twenty consecutive failed attempts, with the last failure landing on the fifth try of track 10. The bench drives it from a per-request plan of stream kinds. Those kinds include a prefix mismatch, a window one bit short of the threshold, a window exactly at it, and a mismatch on the final prefix byte. The plan also steers the block into a mid-stream restart. Random idle cycles on byte_vld spread the accepted bytes over time. A behavioural model predicts every output on every clock.

// File: rtl/sigchk_pkg.sv
package sigchk_pkg;

    localparam int SKIP_BYTES = 64;
    localparam int PFX_BYTES  = 16;
    localparam int WIN_BYTES  = 32;
    localparam int ZERO_MIN   = 204;
    localparam int MAX_TRIES  = 5;
    localparam int TRK_LO     = 7;
    localparam int TRK_HI     = 10;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_DONE  = 2'd3
    } sq_state_e;

    typedef enum logic {
        MODE_DATA  = 1'b0,
        MODE_CLOCK = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic vld;
        logic pass;
    } verdict_t;

    function automatic logic [3:0] zeros8(input logic [7:0] b);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            if (!b[i]) n = n + 4'd1;
        end
        return n;
    endfunction

    function automatic logic [7:0] pfx_const(input rd_mode_e m);
        return (m == MODE_CLOCK) ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/sigchk_zero_acc.sv
module sigchk_zero_acc
    import sigchk_pkg::*;
#(
    parameter int WIN_LEN = WIN_BYTES,
    localparam int ZC_W   = $clog2(WIN_LEN * 8 + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            add_en,
    input  logic [7:0]      byte_data,
    output logic [ZC_W-1:0] total,
    output logic [ZC_W-1:0] total_next
);

    logic [3:0] byte_zeros;

    always_comb begin
        byte_zeros = zeros8(byte_data);
        total_next = total + ZC_W'(byte_zeros);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            total <= '0;
        end else if (add_en) begin
            total <= total_next;
        end
    end

    // R5
    zc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        total <= ZC_W'(WIN_LEN * 8));

endmodule

// File: rtl/sigchk_window.sv
module sigchk_window
    import sigchk_pkg::*;
#(
    parameter int SKIP_LEN = SKIP_BYTES,
    parameter int PFX_LEN  = PFX_BYTES,
    parameter int WIN_LEN  = WIN_BYTES,
    parameter int ZMIN     = ZERO_MIN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  rd_mode_e   mode,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    output verdict_t   verdict
);

    localparam int TOTAL     = SKIP_LEN + PFX_LEN + WIN_LEN;
    localparam int IDX_W     = $clog2(TOTAL);
    localparam int WIN_START = SKIP_LEN + PFX_LEN;
    localparam int ZC_W      = $clog2(WIN_LEN * 8 + 1);

    localparam logic [IDX_W-1:0] PFX_FIRST = IDX_W'(SKIP_LEN);
    localparam logic [IDX_W-1:0] WIN_FIRST = IDX_W'(WIN_START);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(TOTAL - 1);
    localparam logic [ZC_W-1:0]  ZC_MIN    = ZC_W'(ZMIN);

    logic [IDX_W-1:0] idx;
    logic             take;
    logic             in_pfx;
    logic             in_win;
    logic             at_last;
    logic             mismatch;
    logic [ZC_W-1:0]  zc_total;
    logic [ZC_W-1:0]  zc_next;

    always_comb begin
        take     = en && byte_vld;
        in_pfx   = (idx >= PFX_FIRST) && (idx < WIN_FIRST);
        in_win   = (idx >= WIN_FIRST);
        at_last  = (idx == IDX_LAST);
        mismatch = in_pfx && (byte_data != pfx_const(mode));
        verdict.vld  = take && (mismatch || at_last);
        verdict.pass = take && at_last && !mismatch && (zc_next >= ZC_MIN);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (take && !at_last) begin
            idx <= idx + IDX_W'(1);
        end
    end

    sigchk_zero_acc #(
        .WIN_LEN (WIN_LEN)
    ) u_zacc (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .add_en     (take && in_win),
        .byte_data  (byte_data),
        .total      (zc_total),
        .total_next (zc_next)
    );

    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(idx));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_LAST);

    // R5
    zc_window_chk: assert property (@(posedge clk) disable iff (rst)
        (idx <= WIN_FIRST) |-> (zc_total == '0));

endmodule

// File: rtl/sigchk_sequencer.sv
module sigchk_sequencer
    import sigchk_pkg::*;
#(
    parameter int TRIES  = MAX_TRIES,
    parameter int FIRST  = TRK_LO,
    parameter int LAST   = TRK_HI,
    localparam int TRK_W = $clog2(LAST + 1),
    localparam int TRY_W = $clog2(TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  verdict_t         verdict,
    output logic             rd_en,
    output logic             rd_clr,
    output rd_mode_e         rd_mode,
    output logic             req_vld,
    output logic             req_seek,
    output logic [TRK_W-1:0] req_trk,
    output logic             busy,
    output logic             done,
    output logic             pass
);

    localparam logic [TRK_W-1:0] TRK_FIRST = TRK_W'(FIRST);
    localparam logic [TRK_W-1:0] TRK_LAST  = TRK_W'(LAST);
    localparam logic [TRY_W-1:0] TRY_LAST  = TRY_W'(TRIES - 1);

    sq_state_e        state;
    logic [TRK_W-1:0] trk;
    logic [TRY_W-1:0] tries;
    rd_mode_e         mode;
    logic             seek;
    logic             pass_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            trk    <= TRK_FIRST;
            tries  <= '0;
            mode   <= MODE_DATA;
            seek   <= 1'b0;
            pass_r <= 1'b0;
        end else if (start) begin
            state  <= SQ_ISSUE;
            trk    <= TRK_FIRST;
            tries  <= '0;
            mode   <= MODE_DATA;
            seek   <= 1'b1;
            pass_r <= 1'b0;
        end else begin
            unique case (state)
                SQ_ISSUE: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (verdict.vld && verdict.pass) begin
                        if (mode == MODE_DATA) begin
                            mode  <= MODE_CLOCK;
                            seek  <= 1'b0;
                            state <= SQ_ISSUE;
                        end else begin
                            pass_r <= 1'b1;
                            state  <= SQ_DONE;
                        end
                    end else if (verdict.vld) begin
                        mode <= MODE_DATA;
                        if (tries != TRY_LAST) begin
                            tries <= tries + TRY_W'(1);
                            seek  <= 1'b0;
                            state <= SQ_ISSUE;
                        end else if (trk == TRK_LAST) begin
                            pass_r <= 1'b0;
                            state  <= SQ_DONE;
                        end else begin
                            trk   <= trk + TRK_W'(1);
                            tries <= '0;
                            seek  <= 1'b1;
                            state <= SQ_ISSUE;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

    always_comb begin
        rd_en    = (state == SQ_WAIT);
        rd_clr   = (state == SQ_ISSUE) || start;
        rd_mode  = mode;
        req_vld  = (state == SQ_ISSUE);
        req_seek = seek;
        req_trk  = trk;
        busy     = (state == SQ_ISSUE) || (state == SQ_WAIT);
        done     = (state == SQ_DONE);
        pass     = pass_r;
    end

    // R8
    trk_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (req_trk >= TRK_FIRST && req_trk <= TRK_LAST));

    // R7
    try_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tries <= TRY_LAST);

    // R6
    clk_noseek_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode_is_clock()) |-> !req_seek);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(pass) && $stable(req_trk)));

    // R2
    start_req_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (req_vld && req_seek && req_trk == TRK_FIRST && rd_mode == MODE_DATA));

    // R1
    onehot_status_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy, done}));

    function automatic logic req_mode_is_clock();
        return rd_mode == MODE_CLOCK;
    endfunction

endmodule

// File: rtl/sigchk_top.sv
module sigchk_top
    import sigchk_pkg::*;
#(
    parameter int SKIP_LEN = SKIP_BYTES,
    parameter int PFX_LEN  = PFX_BYTES,
    parameter int WIN_LEN  = WIN_BYTES,
    parameter int ZMIN     = ZERO_MIN,
    parameter int TRIES    = MAX_TRIES,
    parameter int FIRST    = TRK_LO,
    parameter int LAST     = TRK_HI,
    localparam int TRK_W   = $clog2(LAST + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    output logic             req_vld,
    output logic             req_seek,
    output logic [TRK_W-1:0] req_trk,
    output logic             req_mode,
    output logic             busy,
    output logic             done,
    output logic             pass
);

    verdict_t verdict;
    logic     rd_en;
    logic     rd_clr;
    rd_mode_e rd_mode;

    sigchk_window #(
        .SKIP_LEN (SKIP_LEN),
        .PFX_LEN  (PFX_LEN),
        .WIN_LEN  (WIN_LEN),
        .ZMIN     (ZMIN)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .clr       (rd_clr),
        .en        (rd_en),
        .mode      (rd_mode),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .verdict   (verdict)
    );

    sigchk_sequencer #(
        .TRIES (TRIES),
        .FIRST (FIRST),
        .LAST  (LAST)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .verdict  (verdict),
        .rd_en    (rd_en),
        .rd_clr   (rd_clr),
        .rd_mode  (rd_mode),
        .req_vld  (req_vld),
        .req_seek (req_seek),
        .req_trk  (req_trk),
        .busy     (busy),
        .done     (done),
        .pass     (pass)
    );

    assign req_mode = rd_mode;

    // R4
    verdict_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        verdict.vld |=> (req_vld || done));

endmodule

// File: tb/sigchk_top_tb.sv
module sigchk_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       req_vld;
    logic       req_seek;
    logic [3:0] req_trk;
    logic       req_mode;
    logic       busy;
    logic       done;
    logic       pass;

    always #2 clk = ~clk;

    sigchk_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .req_vld   (req_vld),
        .req_seek  (req_seek),
        .req_trk   (req_trk),
        .req_mode  (req_mode),
        .busy      (busy),
        .done      (done),
        .pass      (pass)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // stimulus plan and response logs
    int plan_q[$];
    int nreq;
    int log_trk[64];
    int log_seek[64];
    int log_mode[64];
    int sent_cnt[64];
    bit gap_en   = 1'b0;
    bit noise_en = 1'b0;
    bit ractive  = 1'b0;
    int rkind, rmode, ridx, cyc;

    function automatic logic [7:0] gen_byte(input int kind, input int mode, input int i);
        logic [7:0] e;
        int z, n;
        if (i < 64) return (i % 2 == 1) ? 8'h3C : ((mode != 0) ? 8'hFF : 8'h00);
        e = (mode != 0) ? 8'h00 : 8'hFF;
        if (i < 80) begin
            if ((kind == 1 && i == 70) || (kind == 4 && i == 79)) return e ^ 8'h10;
            return e;
        end
        z = (kind == 2) ? 203 : (kind == 3) ? 204 : 230;
        n = (256 - z) - 8 * (i - 80);
        if (n < 0) n = 0;
        if (n > 8) n = 8;
        return 8'((1 << n) - 1);
    endfunction

    // responder: plays the disk side
    initial begin
        byte_vld = 1'b0;
        byte_data = 8'h00;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            byte_vld = 1'b0;
            if (req_vld) begin
                rkind = (plan_q.size() > 0) ? plan_q.pop_front() : 0;
                rmode = int'(req_mode);
                ridx = 0;
                ractive = 1'b1;
                if (nreq < 64) begin
                    log_trk[nreq] = int'(req_trk);
                    log_seek[nreq] = int'(req_seek);
                    log_mode[nreq] = rmode;
                    sent_cnt[nreq] = 0;
                end
                nreq++;
            end else if (ractive && ridx < 112 && !done) begin
                if (!(gap_en && (cyc % 4 == 3))) begin
                    byte_vld = 1'b1;
                    byte_data = gen_byte(rkind, rmode, ridx);
                    ridx++;
                    if (nreq > 0 && nreq <= 64) sent_cnt[nreq-1]++;
                end
            end else if (noise_en) begin
                byte_vld = 1'b1;
                byte_data = 8'(cyc * 37);
            end
        end
    end

    // behavioural reference model
    int ms = 0, mtrk = 7, mtry = 0, mmode = 0, mseek = 0, mpass = 0, midx = 0, mz = 0, mv;

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mpass = 0; mtrk = 7; mtry = 0; mmode = 0; mseek = 0;
        end else if (start) begin
            ms = 1; mtrk = 7; mtry = 0; mmode = 0; mseek = 1; mpass = 0;
        end else if (ms == 1) begin
            ms = 2; midx = 0; mz = 0;
        end else if (ms == 2 && byte_vld) begin
            mv = -1;
            if (midx >= 64 && midx < 80 && byte_data != ((mmode != 0) ? 8'h00 : 8'hFF)) mv = 0;
            if (midx >= 80) mz += 8 - $countones(byte_data);
            if (midx == 111) mv = (mz >= 204) ? 1 : 0;
            midx++;
            if (mv == 1) begin
                if (mmode == 0) begin mmode = 1; mseek = 0; ms = 1; end
                else begin ms = 3; mpass = 1; end
            end else if (mv == 0) begin
                mtry++;
                mmode = 0;
                if (mtry == 5) begin
                    if (mtrk == 10) begin ms = 3; mpass = 0; end
                    else begin mtrk++; mtry = 0; mseek = 1; ms = 1; end
                end else begin
                    mseek = 0; ms = 1;
                end
            end
        end
    end

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            check(req_vld == (ms == 1), "R7 model req_vld", int'(req_vld), int'(ms == 1));
            check(busy == (ms == 1 || ms == 2), "R10 model busy", int'(busy), int'(ms == 1 || ms == 2));
            check(done == (ms == 3), "R9 model done", int'(done), int'(ms == 3));
            if (ms == 3) check(int'(pass) == mpass, "R9 model pass", int'(pass), mpass);
            if (ms == 1) begin
                check(int'(req_trk) == mtrk, "R8 model req_trk", int'(req_trk), mtrk);
                check(int'(req_seek) == mseek, "R8 model req_seek", int'(req_seek), mseek);
                check(int'(req_mode) == mmode, "R6 model req_mode", int'(req_mode), mmode);
            end
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        nreq = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!req_vld && !busy && !done && !pass, "R1 reset state",
              int'({req_vld, busy, done, pass}), 0);

        // R10 idle noise, then R2/R3/R6/R9 single clean pass
        noise_en = 1'b1;
        repeat (20) @(negedge clk);
        check(!busy && !done && !req_vld, "R10 idle noise ignored", int'({busy, done, req_vld}), 0);
        noise_en = 1'b0;
        plan_q = '{0, 0};
        nreq = 0;
        pulse_start();
        wait_done();
        check(nreq == 2, "R3 two reads with hostile skip bytes", nreq, 2);
        check(log_trk[0] == 7 && log_seek[0] == 1 && log_mode[0] == 0, "R2 first request",
              log_trk[0] * 100 + log_seek[0] * 10 + log_mode[0], 710);
        check(log_trk[1] == 7 && log_seek[1] == 0 && log_mode[1] == 1, "R6 clock read follows",
              log_trk[1] * 100 + log_seek[1] * 10 + log_mode[1], 701);
        check(pass && req_trk == 4'd7, "R9 pass on track 7", int'(pass) * 100 + int'(req_trk), 107);
        noise_en = 1'b1;
        repeat (20) @(negedge clk);
        noise_en = 1'b0;
        check(done && pass && req_trk == 4'd7, "R10 done holds under noise",
              int'({done, pass}), 3);

        // R5 threshold edges with gaps
        gap_en = 1'b1;
        plan_q = '{2, 3, 3};
        nreq = 0;
        pulse_start();
        wait_done();
        check(nreq == 3, "R5 203 fails, 204 passes", nreq, 3);
        check(log_trk[1] == 7 && log_seek[1] == 0 && log_mode[1] == 0, "R7 retry after low count",
              log_trk[1] * 100 + log_seek[1] * 10 + log_mode[1], 700);
        check(pass == 1'b1, "R5 exact threshold pass", int'(pass), 1);

        // R4/R7/R8 track 7 exhausted, track 8 passes on second attempt
        plan_q = '{1, 1, 1, 1, 1, 0, 4, 0, 0};
        nreq = 0;
        pulse_start();
        wait_done();
        check(nreq == 9, "R7 request count", nreq, 9);
        check(sent_cnt[0] == 71, "R4 early abort on prefix mismatch", sent_cnt[0], 71);
        check(sent_cnt[6] == 80, "R4 mismatch on last prefix byte", sent_cnt[6], 80);
        check(log_trk[4] == 7 && log_seek[4] == 0, "R7 fifth try same track",
              log_trk[4] * 10 + log_seek[4], 70);
        check(log_trk[5] == 8 && log_seek[5] == 1 && log_mode[5] == 0, "R8 seek to next track",
              log_trk[5] * 100 + log_seek[5] * 10 + log_mode[5], 810);
        check(log_trk[7] == 8 && log_seek[7] == 0 && log_mode[7] == 0, "R7 retry after clock fail",
              log_trk[7] * 100 + log_seek[7] * 10 + log_mode[7], 800);
        check(pass && req_trk == 4'd8, "R9 pass on track 8", int'(pass) * 100 + int'(req_trk), 108);

        // R8/R9 all tracks fail
        plan_q = {};
        for (int i = 0; i < 20; i++) plan_q.push_back(1);
        nreq = 0;
        pulse_start();
        wait_done();
        check(nreq == 20, "R8 twenty attempts", nreq, 20);
        check(log_trk[15] == 10 && log_seek[15] == 1, "R8 last track seek",
              log_trk[15] * 10 + log_seek[15], 101);
        check(done && !pass, "R9 final fail", int'({done, pass}), 2);

        // R11 restart mid-search
        gap_en = 1'b0;
        plan_q = '{1, 1, 1, 1, 1, 1};
        nreq = 0;
        pulse_start();
        for (int i = 0; i < 2000 && nreq < 2; i++) @(negedge clk);
        repeat (30) @(negedge clk);
        check(busy == 1'b1, "R11 busy before restart", int'(busy), 1);
        plan_q = '{0, 0};
        nreq = 0;
        pulse_start();
        wait_done();
        check(nreq == 2, "R11 restart request count", nreq, 2);
        check(log_trk[0] == 7 && log_seek[0] == 1 && log_mode[0] == 0, "R11 restart request",
              log_trk[0] * 100 + log_seek[0] * 10 + log_mode[0], 710);
        check(pass == 1'b1, "R11 pass after restart", int'(pass), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule